// File: doc/BRIEF.md
# ADPCM Nibble Decoder

This block turns a stream of packed 4-bit ADPCM codes into signed audio samples. Each incoming data byte holds two codes. The upper code is decoded first and the lower code on the following clock. Every code adds a signed step to a running 16-bit sample accumulator and then moves a 4-bit step index up or down. The step chosen depends on both the current index and the code. The step index sets how coarse the next step will be, so it follows the loudness of the signal.

A clear input zeroes the accumulator and the step index. It is used when a silent stretch begins and the decoder must restart from a known point. The sample output is the accumulator shifted left by a fixed amount, which gives a wider signed word for a mixer downstream. The step values and index adjustments are computed inside the block. Deciding when bytes arrive is left to the surrounding logic.

Top module: `adpcm_nibble_decoder`

## Requirements
- R1: For each code c (bit 3 is the sign, bits 2:0 are the magnitude m), the accumulator gains step = ±(2·m+1)·BASE[s], where s is the step index before the update. BASE is 16,19,23,28,34,41,50,60,72,87,105,127,154,186,225,272 for s = 0..15. The sign is negative when bit 3 is set.
- R2: After the step is added, the step index changes by −1 when m is 0..3 and by m−2 when m is 4..7. The result is clamped to 0..15.
- R3: The accumulator saturates at +32767 and −32768 and never wraps.
- R4: When byte_valid is accepted, the code in bits 7:4 is applied at that clock edge. The code in bits 3:0 is applied at the next edge.
- R5: A byte_valid in the clock right after an accepted byte, while the low code is still waiting, is ignored.
- R6: clear sets the accumulator and the step index to zero at the next edge. It overrides byte_valid in the same cycle and discards a waiting low code.
- R7: sample_out equals the accumulator shifted left by 7, with bits 6:0 zero. It changes one clock after the edge at which a code is applied. It holds when no code is applied.
- R8: A synchronous active-low reset zeroes the accumulator, the step index and any waiting low code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Zero the accumulator and the step index |
| byte_valid | input | 1 | byte_in holds two codes to decode |
| byte_in | input | 8 | Packed codes, upper code first |
| sample_out | output | 23 | Signed sample, accumulator shifted left by 7 |

## Verification
Two results follow an accepted byte. The upper code's sample appears after the accepting edge, and the lower code's sample appears one edge later. A clear shows zero after its own edge and stays at zero on the edge after it. The bench drives inputs on falling edges. It samples sample_out on the falling edge after each expected update, so each check sees exactly one register stage of latency. Idle cycles are sampled as well, to confirm that ignored bytes and discarded low codes leave the output unchanged.

// File: rtl/adpcm_dec_pkg.sv
// Package: shared widths, types and table functions for the ADPCM nibble decoder.
// Assumes: 4-bit codes, sign in bit 3, 16 step-index levels.
package adpcm_dec_pkg;

    localparam int CODE_W     = 4;
    localparam int BYTE_W     = 2 * CODE_W;
    localparam int ACC_W      = 16;
    localparam int IDX_W      = 4;
    localparam int NUM_IDX    = 1 << IDX_W;
    localparam int NUM_CODES  = 1 << CODE_W;
    localparam int STEP_W     = 13;
    localparam int DELTA_W    = 5;
    localparam int OUT_SHIFT  = 7;
    localparam int OUT_W      = ACC_W + OUT_SHIFT;

    typedef logic signed [STEP_W-1:0]  step_t;
    typedef logic signed [DELTA_W-1:0] delta_t;
    typedef logic signed [ACC_W-1:0]   acc_t;
    typedef logic [IDX_W-1:0]          idx_t;
    typedef logic [CODE_W-1:0]         code_t;

    // Base step size for each step-index level.
    function automatic int base_of(input idx_t s);
        case (s)
            4'd0:  return 16;
            4'd1:  return 19;
            4'd2:  return 23;
            4'd3:  return 28;
            4'd4:  return 34;
            4'd5:  return 41;
            4'd6:  return 50;
            4'd7:  return 60;
            4'd8:  return 72;
            4'd9:  return 87;
            4'd10: return 105;
            4'd11: return 127;
            4'd12: return 154;
            4'd13: return 186;
            4'd14: return 225;
            default: return 272;
        endcase
    endfunction

    // Signed step for index s and code c: +/- (2*m+1)*base.
    function automatic step_t step_of(input idx_t s, input code_t c);
        int mag;
        mag = (2 * int'(c[CODE_W-2:0]) + 1) * base_of(s);
        return c[CODE_W-1] ? step_t'(-mag) : step_t'(mag);
    endfunction

    // Step-index adjustment for a code magnitude.
    function automatic delta_t delta_of(input logic [CODE_W-2:0] m);
        if (m < 3'd4) return -5'sd1;
        return delta_t'(int'(m) - 2);
    endfunction

endpackage

// File: rtl/adpcm_nibble_seq.sv
// Module: splits each accepted byte into two codes, upper code first.
// Assumes: a byte arriving while the lower code waits is dropped; clear wins.
module adpcm_nibble_seq
    import adpcm_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              code_valid,
    output code_t             code,
    output logic              lo_pend
);

    code_t lo_code;

    // Select the code to apply this cycle.
    always_comb begin
        code_valid = !clear && (lo_pend || byte_valid);
        code       = lo_pend ? lo_code : byte_in[BYTE_W-1:CODE_W];
    end

    // Track the waiting lower code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_pend <= 1'b0;
            lo_code <= '0;
        end else if (clear) begin
            lo_pend <= 1'b0;
        end else if (lo_pend) begin
            lo_pend <= 1'b0;
        end else if (byte_valid) begin
            lo_pend <= 1'b1;
            lo_code <= byte_in[CODE_W-1:0];
        end
    end

endmodule

// File: rtl/adpcm_step_lut.sv
// Module: combinational step and index-delta lookup.
// Assumes: one row of steps is built per code by generate, then muxed.
module adpcm_step_lut
    import adpcm_dec_pkg::*;
(
    input  idx_t   idx,
    input  code_t  code,
    output step_t  step,
    output delta_t delta
);

    step_t row [NUM_CODES];

    for (genvar c = 0; c < NUM_CODES; c++) begin : g_row
        // Step for code c at the current index.
        always_comb row[c] = step_of(idx, code_t'(c));
    end

    // Pick the entry for the presented code.
    always_comb begin
        step  = row[code];
        delta = delta_of(code[CODE_W-2:0]);
    end

endmodule

// File: rtl/adpcm_accum.sv
// Module: saturating sample accumulator and clamped step-index register.
// Assumes: clear has priority over code_valid.
module adpcm_accum
    import adpcm_dec_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear,
    input  logic  code_valid,
    input  code_t code,
    output acc_t  acc
);

    localparam logic signed [ACC_W:0] SAT_HI = (ACC_W+1)'((2 ** (ACC_W-1)) - 1);
    localparam logic signed [ACC_W:0] SAT_LO = -(ACC_W+1)'(2 ** (ACC_W-1));
    localparam int IDX_MAX = NUM_IDX - 1;

    idx_t                    idx;
    step_t                   step;
    delta_t                  delta;
    logic signed [ACC_W:0]   sum;
    acc_t                    acc_nxt;
    idx_t                    idx_nxt;
    int                      idx_tmp;

    adpcm_step_lut u_lut (
        .idx   (idx),
        .code  (code),
        .step  (step),
        .delta (delta)
    );

    // Add the step with saturation and move the index with clamping.
    always_comb begin
        sum = $signed({acc[ACC_W-1], acc}) + (ACC_W+1)'(step);
        if (sum > SAT_HI)      acc_nxt = acc_t'(SAT_HI);
        else if (sum < SAT_LO) acc_nxt = acc_t'(SAT_LO);
        else                   acc_nxt = acc_t'(sum);
        idx_tmp = int'(idx) + int'(delta);
        if (idx_tmp < 0)            idx_nxt = '0;
        else if (idx_tmp > IDX_MAX) idx_nxt = idx_t'(IDX_MAX);
        else                        idx_nxt = idx_t'(idx_tmp);
    end

    // Register accumulator and index.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc <= '0;
            idx <= '0;
        end else if (code_valid) begin
            acc <= acc_nxt;
            idx <= idx_nxt;
        end
    end

endmodule

// File: rtl/adpcm_nibble_decoder.sv
// Module: top of the ADPCM nibble decoder; byte in, widened sample out.
// Assumes: output is the registered accumulator shifted left by OUT_SHIFT.
module adpcm_nibble_decoder
    import adpcm_dec_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    byte_valid,
    input  logic [BYTE_W-1:0]       byte_in,
    output logic signed [OUT_W-1:0] sample_out
);

    logic  code_valid;
    code_t code;
    logic  lo_pend;
    acc_t  acc;

    adpcm_nibble_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .code_valid (code_valid),
        .code       (code),
        .lo_pend    (lo_pend)
    );

    adpcm_accum u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .code_valid (code_valid),
        .code       (code),
        .acc        (acc)
    );

    // Widen the accumulator by a fixed shift.
    always_comb sample_out = {acc, {OUT_SHIFT{1'b0}}};

endmodule

// File: rtl/adpcm_nibble_decoder_chk.sv
// Module: assertion checker bound to the decoder top.
module adpcm_nibble_decoder_chk
    import adpcm_dec_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clear,
    input logic                    byte_valid,
    input logic signed [OUT_W-1:0] sample_out,
    input logic                    lo_pend
);

    localparam int STEP_CAP = 15 * 272 * (1 << OUT_SHIFT);

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sample_out == '0)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !byte_valid && !lo_pend) |=> $stable(sample_out)); // R7

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sample_out[OUT_SHIFT-1:0] == '0); // R7

    AST_STEP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((int'(sample_out) - int'($past(sample_out)) <= STEP_CAP) &&
                    (int'(sample_out) - int'($past(sample_out)) >= -STEP_CAP))); // R1

    AST_LOW_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !lo_pend && !clear) |=> lo_pend); // R4

    AST_PEND_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        lo_pend |=> !lo_pend); // R5

endmodule

bind adpcm_nibble_decoder adpcm_nibble_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .byte_valid (byte_valid),
    .sample_out (sample_out),
    .lo_pend    (lo_pend)
);

// File: tb/adpcm_nibble_decoder_tb.sv
module adpcm_nibble_decoder_tb;

    localparam int BASE_TB [16] = '{16, 19, 23, 28, 34, 41, 50, 60,
                                    72, 87, 105, 127, 154, 186, 225, 272};
    localparam int NVEC = 12;
    // {clear, byte}
    localparam logic [8:0] VEC [NVEC] = '{9'h012, 9'h034, 9'h07C, 9'h00F,
                                          9'h088, 9'h0F0, 9'h100, 9'h05A,
                                          9'h0A5, 9'h063, 9'h0E1, 9'h007};

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               clear = 1'b0;
    logic               byte_valid = 1'b0;
    logic [7:0]         byte_in = '0;
    logic signed [22:0] sample_out;

    int checks = 0;
    int fails  = 0;
    int ref_acc = 0;
    int ref_idx = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    adpcm_nibble_decoder u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .sample_out (sample_out)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model for one code (R1, R2, R3).
    task automatic model_code(input logic [3:0] c);
        int mag;
        int m;
        m   = int'(c[2:0]);
        mag = (2 * m + 1) * BASE_TB[ref_idx];
        ref_acc = c[3] ? ref_acc - mag : ref_acc + mag;
        if (ref_acc > 32767)  ref_acc = 32767;
        if (ref_acc < -32768) ref_acc = -32768;
        ref_idx = (m < 4) ? ref_idx - 1 : ref_idx + m - 2;
        if (ref_idx < 0)  ref_idx = 0;
        if (ref_idx > 15) ref_idx = 15;
    endtask

    task automatic send_byte(input logic [7:0] b, input string tag);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_in    = b;
        @(negedge clk);
        byte_valid = 1'b0;
        model_code(b[7:4]);
        chk(int'(sample_out), ref_acc * 128, {tag, " R4 upper code"});
        @(negedge clk);
        model_code(b[3:0]);
        chk(int'(sample_out), ref_acc * 128, {tag, " R4 lower code"});
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        ref_acc = 0;
        ref_idx = 0;
        chk(int'(sample_out), 0, "R6 clear");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(int'(sample_out), 0, "R8 reset state");
        rst_n = 1'b1;

        // Vector table walk (R1, R2, R4, R6, R7).
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][8]) do_clear();
            else send_byte(VEC[i][7:0], "R1 vec");
        end

        // Low clamp: zero codes at index 0 keep the index at 0 (R2).
        do_clear();
        send_byte(8'h00, "R2 clamp");
        send_byte(8'h00, "R2 clamp");
        chk(int'(sample_out), 64 * 128, "R2 index floor");

        // Positive saturation (R3).
        for (int i = 0; i < 20; i++) send_byte(8'h77, "R3 pos");
        chk(int'(sample_out), 32767 * 128, "R3 positive limit");
        // Negative saturation (R3).
        for (int i = 0; i < 20; i++) send_byte(8'hFF, "R3 neg");
        chk(int'(sample_out), -32768 * 128, "R3 negative limit");

        // Byte during waiting lower code is ignored (R5).
        do_clear();
        @(negedge clk);
        byte_valid = 1'b1;
        byte_in    = 8'h52;
        @(negedge clk);
        byte_in    = 8'h77;
        model_code(4'h5);
        chk(int'(sample_out), ref_acc * 128, "R5 upper code");
        @(negedge clk);
        byte_valid = 1'b0;
        model_code(4'h2);
        chk(int'(sample_out), ref_acc * 128, "R5 ignored byte");
        @(negedge clk);
        chk(int'(sample_out), ref_acc * 128, "R7 hold when idle");

        // Clear discards waiting lower code (R6).
        @(negedge clk);
        byte_valid = 1'b1;
        byte_in    = 8'h34;
        @(negedge clk);
        byte_valid = 1'b0;
        clear      = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        chk(int'(sample_out), 0, "R6 clear with waiting code");
        @(negedge clk);
        chk(int'(sample_out), 0, "R6 waiting code dropped");
        ref_acc = 0;
        ref_idx = 0;

        // Clear wins over byte_valid in the same cycle (R6).
        @(negedge clk);
        byte_valid = 1'b1;
        byte_in    = 8'h66;
        clear      = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0;
        clear      = 1'b0;
        chk(int'(sample_out), 0, "R6 clear over byte");
        @(negedge clk);
        chk(int'(sample_out), 0, "R6 no lower code after clear");

        // Index state restarts at 0 after clear (R6).
        send_byte(8'h10, "R6 index zero");

        // Reset mid-run (R8).
        send_byte(8'h7A, "R8 pre");
        @(negedge clk);
        byte_valid = 1'b1;
        byte_in    = 8'h45;
        @(negedge clk);
        byte_valid = 1'b0;
        rst_n      = 1'b0;
        @(negedge clk);
        chk(int'(sample_out), 0, "R8 reset mid-run");
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(sample_out), 0, "R8 no lower code after reset");
        ref_acc = 0;
        ref_idx = 0;
        send_byte(8'h31, "R8 post");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule